// File: doc/BRIEF.md
# Peripheral Access Control Unit

This block guards six peripheral slots. Each slot has a 3-bit access code. The code says whether supervisor-mode and user-mode code may read the peripheral or write it. The codes are held in three byte-wide control registers. Each register carries two slots, and each half of a register has its own lock bit. Software reaches the registers through a small byte-wide register bus at three consecutive offsets from a base parameter.

On every peripheral access the surrounding fabric gives the block three things: the slot index, whether the access is privileged, and whether it is a write. A combinational allow signal comes back in the same cycle. A lock bit that software has set stays set until the next reset. Once either lock in a register is set, the whole register is frozen, and any write to it ends with an error response.

Top module: `periph_guard`

## Requirements
- R1: After reset all three control registers read 0x00. Every slot therefore holds code 000, which gives supervisor read/write and denies user mode.
- R2: Register k (k = 0, 1, 2) sits at bus offset BASE_OFFSET + k, with a default base of 0x24. Bit 7 is the upper lock, bits 6:4 are the upper code, bit 3 is the lower lock and bits 2:0 are the lower code. A read of a mapped register returns its current value with no error.
- R3: A lock bit, once set, stays set until reset. No bus write can clear it.
- R4: A write to a register whose bit 7 or bit 3 is set returns an error, and the register keeps its previous value.
- R5: A write to a mapped register whose lock bits are both clear stores the whole byte, including any lock bits it sets, and returns no error.
- R6: An access of either direction to an offset outside the three registers returns an error. Its read data is 0x00 and no register changes.
- R7: Each cycle with bus_valid high produces exactly one response cycle on the following clock. In that cycle rsp_valid is high and rsp_err and rsp_rdata are valid. rsp_rdata is 0x00 for any response other than a successful read.
- R8: The permission for each code, listed as supervisor / user, is:
  - 000: RW / none
  - 001: R / none
  - 010: R / R
  - 011: R / none
  - 100: RW / RW
  - 101: RW / R
  - 110: RW / RW
  - 111: none / none
- R9: Slot 2k uses the low code of register k, and slot 2k+1 uses its high code.
- R10: Slot indices 6 and 7 are always denied.
- R11: chk_allow is combinational from the stored registers. A register write in the same cycle affects it only after the clock edge that commits the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register bus request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register bus byte offset |
| bus_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Error termination of the request |
| rsp_rdata | output | 8 | Read data |
| chk_slot | input | SLOT_W | Peripheral slot being accessed |
| chk_super | input | 1 | Access is in supervisor mode |
| chk_write | input | 1 | Access is a write |
| chk_allow | output | 1 | Access is permitted |

## Verification
The register bus and the permission path can be active in the same cycle. The bench provokes this by issuing a write that turns slot 0 from code 000 into code 111 while it also queries a supervisor read of slot 0. The query must be allowed before the committing edge and denied after it. A refused write to a locked register is likewise judged against queries made before it and after it, and those queries must keep returning the old permission. Every slot, mode and direction is swept for all eight codes in every register, and the expected results come from bit masks over the code values.

// File: rtl/pg_pkg.sv
package pg_pkg;

  localparam int REG_W  = 8;
  localparam int CODE_W = 3;

  typedef struct packed {
    logic sup_rd;
    logic sup_wr;
    logic usr_rd;
    logic usr_wr;
  } perm_t;

  // pick one of the two code fields of a control byte
  function automatic logic [CODE_W-1:0] field_code(input logic [REG_W-1:0] r, input logic upper);
    return upper ? r[6:4] : r[2:0];
  endfunction

  // either lock bit freezes the whole byte
  function automatic logic lock_set(input logic [REG_W-1:0] r);
    return r[7] | r[3];
  endfunction

  function automatic perm_t decode_code(input logic [CODE_W-1:0] code);
    perm_t p;
    case (code)
      3'b000:  p = '{sup_rd: 1'b1, sup_wr: 1'b1, usr_rd: 1'b0, usr_wr: 1'b0};
      3'b001:  p = '{sup_rd: 1'b1, sup_wr: 1'b0, usr_rd: 1'b0, usr_wr: 1'b0};
      3'b010:  p = '{sup_rd: 1'b1, sup_wr: 1'b0, usr_rd: 1'b1, usr_wr: 1'b0};
      3'b011:  p = '{sup_rd: 1'b1, sup_wr: 1'b0, usr_rd: 1'b0, usr_wr: 1'b0};
      3'b100:  p = '{sup_rd: 1'b1, sup_wr: 1'b1, usr_rd: 1'b1, usr_wr: 1'b1};
      3'b101:  p = '{sup_rd: 1'b1, sup_wr: 1'b1, usr_rd: 1'b1, usr_wr: 1'b0};
      3'b110:  p = '{sup_rd: 1'b1, sup_wr: 1'b1, usr_rd: 1'b1, usr_wr: 1'b1};
      default: p = '0;
    endcase
    return p;
  endfunction

  function automatic logic pick_right(input perm_t p, input logic sup, input logic wr);
    logic r;
    case ({sup, wr})
      2'b11:   r = p.sup_wr;
      2'b10:   r = p.sup_rd;
      2'b01:   r = p.usr_wr;
      default: r = p.usr_rd;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pg_reg_bank.sv
module pg_reg_bank
  import pg_pkg::*;
#(
  parameter int                NUM_REGS = 3,
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] BASE     = 8'h24
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             bus_valid,
  input  logic                             bus_write,
  input  logic [ADDR_W-1:0]                bus_addr,
  input  logic [REG_W-1:0]                 bus_wdata,
  output logic [NUM_REGS-1:0][REG_W-1:0]   regs_q,
  output logic                             rsp_valid,
  output logic                             rsp_err,
  output logic [REG_W-1:0]                 rsp_rdata,
  output logic                             addr_hit,
  output logic                             wr_blocked,
  output logic                             wr_commit
);

  localparam int                IDX_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [ADDR_W-1:0] NREG_A = ADDR_W'(NUM_REGS);

  logic [ADDR_W-1:0] off;
  logic [IDX_W-1:0]  idx;
  logic [REG_W-1:0]  sel_q;
  logic              sel_locked;
  logic              rd_ok;

  assign off      = bus_addr - BASE;
  assign addr_hit = (off < NREG_A);
  assign idx      = off[IDX_W-1:0];

  always_comb begin
    sel_q = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (idx == IDX_W'(i)) sel_q = regs_q[i];
    end
  end

  assign sel_locked = lock_set(sel_q);
  assign wr_blocked = bus_valid & bus_write & addr_hit & sel_locked;
  assign wr_commit  = bus_valid & bus_write & addr_hit & ~sel_locked;
  assign rd_ok      = bus_valid & ~bus_write & addr_hit;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[g] <= '0;
      end else if (wr_commit && (idx == IDX_W'(g))) begin
        regs_q[g] <= bus_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= bus_valid;
      rsp_err   <= bus_valid & (~addr_hit | wr_blocked);
      rsp_rdata <= rd_ok ? sel_q : '0;
    end
  end

endmodule

// File: rtl/pg_perm_decode.sv
module pg_perm_decode
  import pg_pkg::*;
#(
  parameter int NUM_REGS = 3,
  parameter int SLOT_W   = 3
) (
  input  logic [NUM_REGS-1:0][REG_W-1:0]      regs_q,
  output perm_t [(1<<SLOT_W)-1:0]              slot_perm,
  output logic  [(1<<SLOT_W)-1:0][CODE_W-1:0] slot_code
);

  localparam int NUM_SLOTS = 2 * NUM_REGS;
  localparam int SLOT_CAP  = 1 << SLOT_W;

  for (genvar s = 0; s < SLOT_CAP; s++) begin : g_slot
    if (s < NUM_SLOTS) begin : g_live
      assign slot_code[s] = field_code(regs_q[s/2], (s % 2) == 1);
      assign slot_perm[s] = decode_code(slot_code[s]);
    end else begin : g_absent
      // unpopulated slot: behaves as the no-access code
      assign slot_code[s] = '1;
      assign slot_perm[s] = '0;
    end
  end

endmodule

// File: rtl/pg_access_check.sv
module pg_access_check
  import pg_pkg::*;
#(
  parameter int SLOT_W = 3
) (
  input  perm_t [(1<<SLOT_W)-1:0]              slot_perm,
  input  logic  [(1<<SLOT_W)-1:0][CODE_W-1:0] slot_code,
  input  logic  [SLOT_W-1:0]                   chk_slot,
  input  logic                                 chk_super,
  input  logic                                 chk_write,
  output logic                                 chk_allow,
  output logic  [CODE_W-1:0]                   sel_code
);

  perm_t sel_perm;

  assign sel_perm  = slot_perm[chk_slot];
  assign sel_code  = slot_code[chk_slot];
  assign chk_allow = pick_right(sel_perm, chk_super, chk_write);

endmodule

// File: rtl/periph_guard.sv
module periph_guard
  import pg_pkg::*;
#(
  parameter int                NUM_REGS    = 3,
  parameter int                ADDR_W      = 8,
  parameter int                SLOT_W      = 3,
  parameter logic [ADDR_W-1:0] BASE_OFFSET = 8'h24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [7:0]        rsp_rdata,
  input  logic [SLOT_W-1:0] chk_slot,
  input  logic              chk_super,
  input  logic              chk_write,
  output logic              chk_allow
);

  localparam int SLOT_CAP = 1 << SLOT_W;

  logic [NUM_REGS-1:0][REG_W-1:0]   regs_q;
  logic                             addr_hit;
  logic                             wr_blocked;
  logic                             wr_commit;
  perm_t [SLOT_CAP-1:0]             slot_perm;
  logic  [SLOT_CAP-1:0][CODE_W-1:0] slot_code;
  logic  [CODE_W-1:0]               sel_code;

  pg_reg_bank #(
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W),
    .BASE     (BASE_OFFSET)
  ) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .regs_q     (regs_q),
    .rsp_valid  (rsp_valid),
    .rsp_err    (rsp_err),
    .rsp_rdata  (rsp_rdata),
    .addr_hit   (addr_hit),
    .wr_blocked (wr_blocked),
    .wr_commit  (wr_commit)
  );

  pg_perm_decode #(
    .NUM_REGS (NUM_REGS),
    .SLOT_W   (SLOT_W)
  ) u_decode (
    .regs_q    (regs_q),
    .slot_perm (slot_perm),
    .slot_code (slot_code)
  );

  pg_access_check #(
    .SLOT_W (SLOT_W)
  ) u_check (
    .slot_perm (slot_perm),
    .slot_code (slot_code),
    .chk_slot  (chk_slot),
    .chk_super (chk_super),
    .chk_write (chk_write),
    .chk_allow (chk_allow),
    .sel_code  (sel_code)
  );

endmodule

// File: rtl/periph_guard_chk.sv
module periph_guard_chk #(
  parameter int NUM_REGS = 3,
  parameter int SLOT_W   = 3
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        bus_valid,
  input logic                        rsp_valid,
  input logic                        rsp_err,
  input logic                        addr_hit,
  input logic                        wr_blocked,
  input logic                        wr_commit,
  input logic [NUM_REGS-1:0][7:0]    regs_q,
  input logic [SLOT_W-1:0]           chk_slot,
  input logic                        chk_allow,
  input logic [2:0]                  sel_code
);

  localparam logic [SLOT_W:0] NSLOT = (SLOT_W+1)'(2 * NUM_REGS);

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |=> rsp_valid); // R7

  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> !rsp_valid); // R7

  AST_BLOCKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |=> (rsp_err && $stable(regs_q))); // R4

  AST_COMMIT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> !rsp_err); // R5

  AST_MISS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !addr_hit) |=> (rsp_err && $stable(regs_q))); // R6

  AST_HIGH_SLOT_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, chk_slot} >= NSLOT) |-> !chk_allow); // R10

  AST_CODE7_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_code == 3'b111) |-> !chk_allow); // R8

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_lock
    AST_LOCK_HI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      regs_q[i][7] |=> regs_q[i][7]); // R3
    AST_LOCK_LO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      regs_q[i][3] |=> regs_q[i][3]); // R3
  end

endmodule

bind periph_guard periph_guard_chk #(
  .NUM_REGS (NUM_REGS),
  .SLOT_W   (SLOT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_valid  (bus_valid),
  .rsp_valid  (rsp_valid),
  .rsp_err    (rsp_err),
  .addr_hit   (addr_hit),
  .wr_blocked (wr_blocked),
  .wr_commit  (wr_commit),
  .regs_q     (regs_q),
  .chk_slot   (chk_slot),
  .chk_allow  (chk_allow),
  .sel_code   (sel_code)
);

// File: tb/periph_guard_test.sv
module periph_guard_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_valid = 1'b0;
  logic       bus_write = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic       rsp_valid;
  logic       rsp_err;
  logic [7:0] rsp_rdata;
  logic [2:0] chk_slot = 3'd0;
  logic       chk_super = 1'b0;
  logic       chk_write = 1'b0;
  logic       chk_allow;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [7:0] shadow [3];

  always #2 clk = ~clk;

  periph_guard uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata),
    .chk_slot  (chk_slot),
    .chk_super (chk_super),
    .chk_write (chk_write),
    .chk_allow (chk_allow)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // permission masks indexed by code value
  function automatic bit exp_allow(input int slot, input bit sup, input bit wr);
    logic [7:0] m;
    logic [2:0] code;
    if (slot >= 6) return 1'b0;
    code = (slot % 2 == 1) ? shadow[slot/2][6:4] : shadow[slot/2][2:0];
    if (sup) m = wr ? 8'h71 : 8'h7F;
    else     m = wr ? 8'h50 : 8'h74;
    return m[code];
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 3; k++) shadow[k] = 8'h00;
  endtask

  // one bus transfer; checks the response against the shadow model
  task automatic bus_op(input string req, input bit wr, input logic [7:0] addr, input logic [7:0] data);
    int  k;
    bit  hit;
    bit  locked;
    int  exp_err;
    int  exp_rd;
    k      = int'(addr) - 'h24;
    hit    = (k >= 0) && (k < 3);
    locked = hit ? (shadow[k][7] | shadow[k][3]) : 1'b0;
    exp_err = (!hit || (wr && locked)) ? 1 : 0;
    exp_rd  = (hit && !wr) ? int'(shadow[k]) : 0;
    @(negedge clk);
    bus_valid = 1'b1;
    bus_write = wr;
    bus_addr  = addr;
    bus_wdata = data;
    @(negedge clk);
    bus_valid = 1'b0;
    check({req, " rsp_valid"}, int'(rsp_valid), 1);
    check({req, " rsp_err"}, int'(rsp_err), exp_err);
    check({req, " rsp_rdata"}, int'(rsp_rdata), exp_rd);
    if (wr && hit && !locked) shadow[k] = data;
  endtask

  task automatic read_back(input string req, input int k);
    bus_op(req, 1'b0, 8'(8'h24 + k), 8'h00);
  endtask

  task automatic sweep_slots(input string req);
    for (int s = 0; s < 8; s++) begin
      for (int m = 0; m < 4; m++) begin
        chk_slot  = 3'(s);
        chk_super = m[1];
        chk_write = m[0];
        #1;
        check($sformatf("%s slot%0d sup%0d wr%0d", (s >= 6) ? "R10" : req, s, m[1], m[0]),
              int'(chk_allow), int'(exp_allow(s, m[1], m[0])));
      end
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 3; k++) shadow[k] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values and default permissions
    for (int k = 0; k < 3; k++) read_back("R1 reset", k);
    sweep_slots("R1");

    // R7: response lasts exactly one cycle
    @(negedge clk);
    check("R7 idle rsp_valid", int'(rsp_valid), 0);

    // R8 R9 R2 R5: every code in every register, both halves
    for (int k = 0; k < 3; k++) begin
      for (int c = 0; c < 8; c++) begin
        logic [7:0] v;
        v = {1'b0, 3'((c + 3) % 8), 1'b0, 3'(c)};
        bus_op("R5 write", 1'b1, 8'(8'h24 + k), v);
        read_back("R2 read", k);
        sweep_slots("R8/R9");
      end
    end

    // R6: unmapped offsets, both directions
    bus_op("R6 below", 1'b0, 8'h23, 8'h00);
    bus_op("R6 above", 1'b1, 8'h27, 8'hFF);
    bus_op("R6 far", 1'b1, 8'h00, 8'h88);
    for (int k = 0; k < 3; k++) read_back("R6 untouched", k);

    // R11: write and check in the same cycle
    bus_op("R5 prep", 1'b1, 8'h24, 8'h00);
    @(negedge clk);
    bus_valid = 1'b1;
    bus_write = 1'b1;
    bus_addr  = 8'h24;
    bus_wdata = 8'h07;
    chk_slot  = 3'd0;
    chk_super = 1'b1;
    chk_write = 1'b0;
    #1;
    check("R11 before edge", int'(chk_allow), 1);
    @(negedge clk);
    bus_valid = 1'b0;
    #1;
    check("R11 after edge", int'(chk_allow), 0);
    shadow[0] = 8'h07;

    // R4 R3: low lock on reg1, high lock on reg2
    bus_op("R5 set lock0", 1'b1, 8'h25, 8'h0D);
    bus_op("R4 locked write", 1'b1, 8'h25, 8'h45);
    read_back("R4 unchanged", 1);
    sweep_slots("R4");
    bus_op("R3 try clear", 1'b1, 8'h25, 8'h00);
    read_back("R3 still set", 1);
    bus_op("R5 set lock1", 1'b1, 8'h26, 8'hE0);
    bus_op("R4 locked hi", 1'b1, 8'h26, 8'h00);
    read_back("R3 hi still set", 2);
    bus_op("R5 reg0 free", 1'b1, 8'h24, 8'h4C);
    read_back("R5 reg0", 0);
    bus_op("R4 reg0 locked", 1'b1, 8'h24, 8'h11);
    sweep_slots("R4");

    // R3 R1: only reset clears the locks
    do_reset();
    for (int k = 0; k < 3; k++) read_back("R3 reset clears", k);
    bus_op("R5 after reset", 1'b1, 8'h25, 8'h62);
    read_back("R5 after reset", 1);
    sweep_slots("R9");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule